// File: doc/BRIEF.md
# Emulator Register Chip-Select Decoder

This block lets a debug or development setup take over a group of on-chip port registers with logic outside the chip. While reset is held it keeps sampling three strap pins: two data bus bits and the bus-error line. The strap pattern present in the last reset cycle sets an emulation flag. That flag then holds until the next reset.

With the flag set, the block compares the word address of every bus cycle against a parameter table of externally mapped register addresses. A bus cycle begins when the address strobe is seen low. For an address in the table, the block raises the emulator select and keeps the internal register file from responding. It also paces the access to a fixed number of clocks by pulsing a transfer acknowledge once. Any other address is left to the internal registers. The select drops at the first clock edge that sees the address strobe high again.

Top module: `emu_regsel_top`

## Requirements
- R1: The emulation flag is set only when, in the last clock cycle with `rst_n` low, `strap_d10` = 0, `strap_berr` = 1 and `strap_d1` = 0. The flag keeps its value after reset, whatever the straps do later.
- R2: With the flag clear, `emu_sel` and `xfer_ack` never assert, and every strobed access raises `int_resp_en`.
- R3: With the flag set, an access whose word address `addr[AW-1:1]` equals an entry of `EXT_WADDR` raises `emu_sel` from the first clock edge that samples `as_n` low. `emu_sel` stays high until the first edge that samples `as_n` high. By default the table holds the 11 byte addresses 0xFFFA00, 0xFFFA02, …, 0xFFFA14.
- R4: While `emu_sel` is high, `int_resp_en` is low.
- R5: An access whose word address is not in the table raises `int_resp_en` for the same window that R3 defines, and leaves `emu_sel` low.
- R6: During an external access, `xfer_ack` is high for exactly one clock: the ACC_CYC-th cycle (default 3), where the cycle opened by the start edge counts as 1. If the strobe rises earlier, no acknowledge is given.
- R7: The byte-select bit `addr[0]` has no effect on the match.
- R8: While `rst_n` is low, all three outputs are low from the first clock edge onward.
- R9: The decision between external and internal access is taken at the start edge. Changes on `addr` while the strobe stays low do not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; straps are sampled while it is low |
| strap_d10 | input | 1 | Data bit 10 level used as a mode strap |
| strap_berr | input | 1 | Bus-error line level used as a mode strap |
| strap_d1 | input | 1 | Data bit 1 level used as a mode strap |
| addr | input | AW | Byte address of the bus cycle |
| as_n | input | 1 | Address strobe, active low |
| rw | input | 1 | Read (1) / write (0); both directions are decoded alike |
| emu_sel | output | 1 | Emulator chip select, active high |
| int_resp_en | output | 1 | Lets the internal registers answer the current access |
| xfer_ack | output | 1 | One-clock acknowledge closing an external access |

## Verification
The bench builds the block with AW = 24, NREG = 11, ACC_CYC = 3 and the default contiguous table. It therefore knows every mapped address and can aim stimulus just inside and just outside the table edges, at 0xFFFA14 and 0xFFFA16. With ACC_CYC = 3, strobes of one and two cycles are short enough to reach the no-acknowledge case, and longer strobes show that the select is held after the acknowledge. All eight strap patterns are driven through reset, so the flag decode is covered in full.

// File: rtl/emu_regsel_pkg.sv
package emu_regsel_pkg;

    // Strap pattern that selects emulation: d10 low, berr high, d1 low.
    function automatic logic strap_selects_emu(input logic d10, input logic berr, input logic d1);
        return (!d10) && berr && (!d1);
    endfunction

    typedef enum logic [1:0] {
        ACC_IDLE = 2'd0,
        ACC_INT  = 2'd1,
        ACC_EXT  = 2'd2
    } acc_kind_e;

endpackage

// File: rtl/emu_mode_strap.sv
module emu_mode_strap
    import emu_regsel_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic strap_d10,
    input  logic strap_berr,
    input  logic strap_d1,
    output logic emu_mode
);
    logic mode_d, mode_q;

    always_comb begin
        mode_d = mode_q;
        if (!rst_n) begin
            mode_d = strap_selects_emu(strap_d10, strap_berr, strap_d1);
        end
    end

    always_ff @(posedge clk) begin
        mode_q <= mode_d;
    end

    assign emu_mode = mode_q;
endmodule

// File: rtl/emu_addr_match.sv
module emu_addr_match #(
    parameter int AW   = 24,
    parameter int NREG = 11,
    parameter logic [NREG-1:0][AW-2:0] EXT_WADDR = '0
) (
    input  logic [AW-1:0] addr,
    output logic          hit
);
    localparam int WAW = AW - 1;

    logic [WAW-1:0]  waddr;
    logic [NREG-1:0] hits;

    assign waddr = addr[AW-1:1];

    for (genvar i = 0; i < NREG; i++) begin : g_cmp
        assign hits[i] = (waddr == EXT_WADDR[i]);
    end

    assign hit = |hits;
endmodule

// File: rtl/emu_access_seq.sv
module emu_access_seq
    import emu_regsel_pkg::*;
#(
    parameter int ACC_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic emu_mode,
    input  logic addr_hit,
    input  logic as_n,
    output logic emu_sel,
    output logic int_resp_en,
    output logic xfer_ack
);
    localparam int CW = $clog2(ACC_CYC + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(ACC_CYC);

    typedef struct packed {
        acc_kind_e       kind;
        logic [CW-1:0]   cnt;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (as_n) begin
            s_d.kind = ACC_IDLE;
            s_d.cnt  = '0;
        end else if (s_q.kind == ACC_IDLE) begin
            s_d.kind = (emu_mode && addr_hit) ? ACC_EXT : ACC_INT;
            s_d.cnt  = CW'(1);
        end else if (s_q.kind == ACC_EXT) begin
            if (s_q.cnt == CNT_LAST) begin
                s_d.cnt = '0;
            end else if (s_q.cnt != '0) begin
                s_d.cnt = s_q.cnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{kind: ACC_IDLE, cnt: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign emu_sel     = (s_q.kind == ACC_EXT);
    assign int_resp_en = (s_q.kind == ACC_INT);
    assign xfer_ack    = (s_q.kind == ACC_EXT) && (s_q.cnt == CNT_LAST);
endmodule

// File: rtl/emu_regsel_top.sv
module emu_regsel_top #(
    parameter int AW      = 24,
    parameter int NREG    = 11,
    parameter int ACC_CYC = 3,
    parameter logic [NREG-1:0][AW-2:0] EXT_WADDR = {
        23'h7FFD0A, 23'h7FFD09, 23'h7FFD08, 23'h7FFD07, 23'h7FFD06, 23'h7FFD05,
        23'h7FFD04, 23'h7FFD03, 23'h7FFD02, 23'h7FFD01, 23'h7FFD00 }
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          strap_d10,
    input  logic          strap_berr,
    input  logic          strap_d1,
    input  logic [AW-1:0] addr,
    input  logic          as_n,
    input  logic          rw,
    output logic          emu_sel,
    output logic          int_resp_en,
    output logic          xfer_ack
);
    logic emu_mode;
    logic addr_hit;
    logic rw_unused;

    // Reads and writes are decoded the same way.
    assign rw_unused = rw;

    emu_mode_strap i_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .strap_d10  (strap_d10),
        .strap_berr (strap_berr),
        .strap_d1   (strap_d1),
        .emu_mode   (emu_mode)
    );

    emu_addr_match #(
        .AW        (AW),
        .NREG      (NREG),
        .EXT_WADDR (EXT_WADDR)
    ) i_match (
        .addr (addr),
        .hit  (addr_hit)
    );

    emu_access_seq #(
        .ACC_CYC (ACC_CYC)
    ) i_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .emu_mode    (emu_mode),
        .addr_hit    (addr_hit),
        .as_n        (as_n),
        .emu_sel     (emu_sel),
        .int_resp_en (int_resp_en),
        .xfer_ack    (xfer_ack)
    );
endmodule

// File: rtl/emu_regsel_checker.sv
module emu_regsel_checker (
    input logic clk,
    input logic rst_n,
    input logic as_n,
    input logic emu_mode,
    input logic emu_sel,
    input logic int_resp_en,
    input logic xfer_ack
);
    a_r8_quiet_in_reset: assert property (@(posedge clk)
        !rst_n |=> (!emu_sel && !int_resp_en && !xfer_ack));

    a_r1_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(emu_mode));

    a_r2_no_sel_outside: assert property (@(posedge clk) disable iff (!rst_n)
        !emu_mode |-> (!emu_sel && !xfer_ack));

    a_r3_drop_on_strobe_high: assert property (@(posedge clk) disable iff (!rst_n)
        as_n |=> (!emu_sel && !int_resp_en));

    a_r3_hold_while_low: assert property (@(posedge clk) disable iff (!rst_n)
        (emu_sel && !as_n) |=> emu_sel);

    a_r4_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(emu_sel && int_resp_en));

    a_r6_ack_inside_sel: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_ack |-> emu_sel);

    a_r6_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_ack |=> !xfer_ack);
endmodule

bind emu_regsel_top emu_regsel_checker i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .as_n        (as_n),
    .emu_mode    (emu_mode),
    .emu_sel     (emu_sel),
    .int_resp_en (int_resp_en),
    .xfer_ack    (xfer_ack)
);

// File: tb/test_emu_regsel_top.sv
module test_emu_regsel_top;
    localparam int AW = 24;
    localparam int NREG = 11;
    localparam int ACC = 3;
    localparam logic [AW-1:0] TBL_BASE = 24'hFFFA00;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic s10 = 1'b1, sberr = 1'b0, s1 = 1'b1;
    logic [AW-1:0] addr = '0;
    logic as_n = 1'b1;
    logic rw = 1'b1;
    logic emu_sel, int_resp_en, xfer_ack;

    int checks = 0;
    int errors = 0;
    logic cur_mode = 1'b0;

    always #2 clk = ~clk;

    emu_regsel_top i_emu_regsel_top (
        .clk(clk), .rst_n(rst_n), .strap_d10(s10), .strap_berr(sberr), .strap_d1(s1),
        .addr(addr), .as_n(as_n), .rw(rw),
        .emu_sel(emu_sel), .int_resp_en(int_resp_en), .xfer_ack(xfer_ack)
    );

    function automatic logic in_table(input logic [AW-1:0] a);
        logic [AW-2:0] w = a[AW-1:1];
        for (int i = 0; i < NREG; i++) begin
            if (w == TBL_BASE[AW-1:1] + (AW-1)'(i)) return 1'b1;
        end
        return 1'b0;
    endfunction

    task automatic check3(input string req, input logic es, input logic ir, input logic ak);
        checks++;
        if (emu_sel !== es || int_resp_en !== ir || xfer_ack !== ak) begin
            errors++;
            $display("FAIL %s: sel/int/ack actual %b%b%b expected %b%b%b",
                     req, emu_sel, int_resp_en, xfer_ack, es, ir, ak);
        end
    endtask

    // R8 and R1: reset with a given strap pattern, then scramble the straps.
    task automatic do_reset(input logic d10, input logic be, input logic d1);
        @(negedge clk);
        rst_n = 1'b0; as_n = 1'b1; s10 = d10; sberr = be; s1 = d1;
        repeat (3) @(negedge clk);
        check3("R8", 1'b0, 1'b0, 1'b0);
        rst_n = 1'b1;
        cur_mode = !d10 && be && !d1;
        s10 = ~d10; sberr = ~be; s1 = ~d1;
    endtask

    // One access; samples every cycle at the negedge. Requirements R2..R7, R9.
    task automatic access(input logic [AW-1:0] a, input int len, input logic wobble);
        logic ext;
        ext = cur_mode && in_table(a);
        @(negedge clk);
        addr = a; as_n = 1'b0; rw = $urandom % 2;
        for (int i = 1; i <= len; i++) begin
            @(negedge clk);
            check3(ext ? "R3_R4_R6" : (cur_mode ? "R5_R7" : "R2"),
                   ext, !ext, ext && (i == ACC));
            if (wobble) addr = $urandom; // R9: decision must not change
        end
        as_n = 1'b1;
        @(negedge clk);
        check3("R3_release", 1'b0, 1'b0, 1'b0);
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        // R1: all eight strap patterns, probed with an in-table address.
        for (int p = 0; p < 8; p++) begin
            do_reset(p[2], p[1], p[0]);
            access(TBL_BASE + 24'h4, 4, 1'b0);
        end
        // R2: mode off
        do_reset(1'b1, 1'b1, 1'b0);
        access(TBL_BASE, 5, 1'b0);
        access(TBL_BASE + 24'h40, 2, 1'b0);
        // Mode on: directed corners
        do_reset(1'b0, 1'b1, 1'b0);
        access(TBL_BASE + 24'h14, 5, 1'b0);   // R3: last entry
        access(TBL_BASE + 24'h16, 4, 1'b0);   // R5: first address past table
        access(TBL_BASE + 24'h15, 4, 1'b0);   // R7: odd byte of last entry
        access(TBL_BASE - 24'h1, 4, 1'b0);    // R5: just below table
        access(TBL_BASE + 24'h2, 1, 1'b0);    // R6: strobe too short for ack
        access(TBL_BASE + 24'h2, 2, 1'b0);    // R6: strobe too short for ack
        access(TBL_BASE + 24'h8, 3, 1'b0);    // R6: ack in last cycle
        access(TBL_BASE + 24'h6, 6, 1'b1);    // R9: address wobble, external
        access(TBL_BASE + 24'h30, 6, 1'b1);   // R9: address wobble, internal
        // Random mix
        for (int k = 0; k < 300; k++) begin
            logic [AW-1:0] a;
            int sel = $urandom % 3;
            if (sel == 0) a = TBL_BASE + AW'(($urandom % NREG) * 2) + AW'($urandom % 2);
            else if (sel == 1) a = TBL_BASE + AW'($urandom % 64);
            else a = $urandom;
            if (k == 150) do_reset(1'b1, 1'b0, 1'b0);
            if (k == 220) do_reset(1'b0, 1'b1, 1'b0);
            access(a, 1 + int'($urandom % 6), ($urandom % 4) == 0);
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule